// File: doc/BRIEF.md
# Floating-Point Control Register with Mode Resolver

This block holds the floating-point control state of a core: sticky exception flags, a dynamic rounding mode and a dynamic result-accuracy mode. Software reads and changes these fields through CSR accesses. An access may write the field outright, or set or clear bits in it. It may address the whole packed register or any one field alone. Completing FP operations report exception flags, and the block ORs them into the sticky flags.

For each FP instruction at issue, the block takes the instruction's static rounding field and an operation class. On the same cycle it returns the effective rounding mode and the effective accuracy mode, or it raises an illegal-instruction trap request. Supported pairs of accuracy mode and operation class come from a parameter mask. A request the datapath cannot meet exactly may be served with a stricter supported mode. A request with no stricter supported mode traps, so that software can emulate it.

Top module: `fp_mode_csr`

## Requirements
- R1: After reset the flags, the rounding mode and the accuracy mode are all zero. Accuracy code 000 means correctly rounded.
- R2: The full view packs the fields as follows: flags in bits 4..0, rounding mode in bits 7..5, accuracy in bits 10..8. Bits 31..11 always read zero. Read data is the value before the access and is zero when no access is presented.
- R3: Operation code 1 writes, 2 sets (OR) and 3 clears (AND-NOT) the addressed bits on the next clock. Code 0 only reads. Bits 31..11 of write data have no effect.
- R4: View code 0 is the full register, 1 is the rounding mode, 2 is the flags and 3 is the accuracy mode. Single-field views take and return data right-aligned and reach the same storage as the full view.
- R5: When flag-valid is high, the reported flags are ORed into the sticky flags. A CSR change to the flags in the same cycle wins on the bits it touches: a write replaces all bits, a clear removes bits even while they are being reported, and a set adds bits.
- R6: A static rounding field other than 111 is passed through unchanged. The value 111 selects the stored rounding mode.
- R7: A trap is requested when 111 selects a stored rounding mode of 101, 110 or 111.
- R8: Accuracy codes are 000 (correctly rounded), 010 (under one ULP), 100 (graphics-API bound) and 110 (approximate). A lower even code is stricter. A supported pair returns the requested code. The default support is: class 0 {000,110}, class 1 {000,100}, class 2 {000}, class 3 none.
- R9: For an unsupported pair, the block returns the nearest stricter supported code. If there is none, as for class 3, it raises a trap.
- R10: Odd accuracy codes (001, 011, 101, 111) always trap on issue.
- R11: On a trap, result-valid is low and both resolved modes read zero. With no issue, all issue outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | CSR access presented |
| csrOp | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csrView | input | 2 | 0 full, 1 rounding, 2 flags, 3 accuracy |
| csrWdata | input | 32 | Access data, right-aligned for field views |
| csrRdata | output | 32 | Value of the addressed view before the access |
| flagValid | input | 1 | Completing operation reports flags |
| flagBits | input | 5 | Reported exception flags |
| issValid | input | 1 | FP instruction at issue |
| issRm | input | 3 | Static rounding field of the instruction |
| issClass | input | 2 | Operation class |
| resValid | output | 1 | Modes resolved without trap |
| resRm | output | 3 | Effective rounding mode |
| resAcc | output | 3 | Effective accuracy mode |
| trapReq | output | 1 | Illegal-instruction trap request |

## Verification
The resolver is driven with random static rounding fields, half of which select the stored mode. Writes keep loading random values into the stored rounding mode, including the reserved values 101 to 111, so the tests separate pass-through, dynamic selection and the trap on reserved values. Writes also cycle the stored accuracy through all eight codes while the class varies over all four values. This covers exact grants, promotion to a stricter mode, traps on odd codes and traps on the class that has no support. Random set, clear and write accesses through every view are mixed with flag reports in the same cycles, which shows whether the CSR change or the accumulation wins on each bit. Directed cases pin down the full-view packing and the reserved bits, a clear that collides with a reported flag, and the promotion results.

// File: rtl/fp_mode_pkg.sv
package fp_mode_pkg;
  localparam int FLAG_W = 5;
  localparam int MODE_W = 3;
  localparam int CSR_W  = 32;
  localparam int RND_LSB = FLAG_W;
  localparam int ACC_LSB = FLAG_W + MODE_W;
  localparam int USED_W  = FLAG_W + 2 * MODE_W;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    VIEW_ALL = 2'd0,
    VIEW_RND = 2'd1,
    VIEW_FLG = 2'd2,
    VIEW_ACC = 2'd3
  } csr_view_e;

  typedef struct packed {
    logic              flagsEn;
    logic              rndEn;
    logic              accEn;
    csr_op_e           op;
    logic [FLAG_W-1:0] flagsVal;
    logic [MODE_W-1:0] rndVal;
    logic [MODE_W-1:0] accVal;
  } csr_strobe_t;

  function automatic logic [FLAG_W-1:0] applyOp(csr_op_e op, logic [FLAG_W-1:0] cur,
                                                logic [FLAG_W-1:0] val);
    case (op)
      OP_WRITE: applyOp = val;
      OP_SET:   applyOp = cur | val;
      OP_CLEAR: applyOp = cur & ~val;
      default:  applyOp = cur;
    endcase
  endfunction
endpackage

// File: rtl/fp_acc_resolve.sv
module fp_acc_resolve #(
  parameter int NUM_CLASS = 3,
  parameter int CLASS_W = 2,
  parameter logic [NUM_CLASS*8-1:0] ACC_SUPPORT = 24'h01_11_41,
  parameter bit PROMOTE = 1'b1
) (
  input  logic [2:0]         reqAcc,
  input  logic [CLASS_W-1:0] opClass,
  output logic [2:0]         grantAcc,
  output logic               unsupported
);
  localparam int CODES = 8;

  logic [CODES-1:0] classMask [NUM_CLASS];

  for (genvar c = 0; c < NUM_CLASS; c++) begin : gClass
    assign classMask[c] = ACC_SUPPORT[c*CODES +: CODES];
  end

  logic [CODES-1:0] mask;
  logic             found;

  always_comb begin
    mask = '0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      if (int'(opClass) == c) mask = classMask[c];
    end
    found = 1'b0;
    grantAcc = 3'd0;
    if (!reqAcc[0]) begin
      for (int k = 0; k < CODES; k += 2) begin
        if (mask[k] && (k <= int'(reqAcc)) && (PROMOTE || k == int'(reqAcc))) begin
          found = 1'b1;
          grantAcc = 3'(k);
        end
      end
    end
    unsupported = !found;
  end
endmodule

// File: rtl/fp_mode_regs.sv
module fp_mode_regs
  import fp_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strobe,
  input  logic              flagValid,
  input  logic [FLAG_W-1:0] flagBits,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [MODE_W-1:0] rndQ,
  output logic [MODE_W-1:0] accQ
);
  logic [FLAG_W-1:0] flagsAccum;
  logic [FLAG_W-1:0] flagsNext;
  logic [MODE_W-1:0] rndNext;
  logic [MODE_W-1:0] accNext;

  always_comb begin
    flagsAccum = flagsQ | (flagValid ? flagBits : '0);
    flagsNext  = strobe.flagsEn ? applyOp(strobe.op, flagsAccum, strobe.flagsVal) : flagsAccum;
    rndNext    = strobe.rndEn
               ? MODE_W'(applyOp(strobe.op, FLAG_W'(rndQ), FLAG_W'(strobe.rndVal))) : rndQ;
    accNext    = strobe.accEn
               ? MODE_W'(applyOp(strobe.op, FLAG_W'(accQ), FLAG_W'(strobe.accVal))) : accQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      rndQ   <= '0;
      accQ   <= '0;
    end else begin
      flagsQ <= flagsNext;
      rndQ   <= rndNext;
      accQ   <= accNext;
    end
  end
endmodule

// File: rtl/fp_mode_ctrl.sv
module fp_mode_ctrl
  import fp_mode_pkg::*;
#(
  parameter int NUM_CLASS = 3,
  parameter int CLASS_W = 2,
  parameter logic [NUM_CLASS*8-1:0] ACC_SUPPORT = 24'h01_11_41,
  parameter bit PROMOTE = 1'b1
) (
  input  logic               csrValid,
  input  logic [1:0]         csrOp,
  input  logic [1:0]         csrView,
  input  logic [CSR_W-1:0]   csrWdata,
  output logic [CSR_W-1:0]   csrRdata,
  input  logic [FLAG_W-1:0]  flagsQ,
  input  logic [MODE_W-1:0]  rndQ,
  input  logic [MODE_W-1:0]  accQ,
  output csr_strobe_t        strobe,
  input  logic               issValid,
  input  logic [2:0]         issRm,
  input  logic [CLASS_W-1:0] issClass,
  output logic               resValid,
  output logic [2:0]         resRm,
  output logic [2:0]         resAcc,
  output logic               trapReq
);
  csr_op_e   op;
  csr_view_e view;
  logic      change;
  logic      unusedHi;

  assign op       = csr_op_e'(csrOp);
  assign view     = csr_view_e'(csrView);
  assign change   = csrValid && (op != OP_READ);
  assign unusedHi = ^csrWdata[CSR_W-1:USED_W];

  always_comb begin
    strobe          = '0;
    strobe.op       = op;
    strobe.flagsEn  = change && (view == VIEW_ALL || view == VIEW_FLG);
    strobe.rndEn    = change && (view == VIEW_ALL || view == VIEW_RND);
    strobe.accEn    = change && (view == VIEW_ALL || view == VIEW_ACC);
    if (view == VIEW_ALL) begin
      strobe.flagsVal = csrWdata[FLAG_W-1:0];
      strobe.rndVal   = csrWdata[RND_LSB +: MODE_W];
      strobe.accVal   = csrWdata[ACC_LSB +: MODE_W];
    end else begin
      strobe.flagsVal = csrWdata[FLAG_W-1:0];
      strobe.rndVal   = csrWdata[MODE_W-1:0];
      strobe.accVal   = csrWdata[MODE_W-1:0];
    end
  end

  always_comb begin
    csrRdata = '0;
    if (csrValid) begin
      case (view)
        VIEW_ALL: csrRdata = CSR_W'({accQ, rndQ, flagsQ});
        VIEW_RND: csrRdata = CSR_W'(rndQ);
        VIEW_FLG: csrRdata = CSR_W'(flagsQ);
        default:  csrRdata = CSR_W'(accQ);
      endcase
    end
  end

  logic [2:0] grantAcc;
  logic       accUnsup;

  fp_acc_resolve #(
    .NUM_CLASS(NUM_CLASS), .CLASS_W(CLASS_W),
    .ACC_SUPPORT(ACC_SUPPORT), .PROMOTE(PROMOTE)
  ) uResolve (
    .reqAcc(accQ), .opClass(issClass),
    .grantAcc(grantAcc), .unsupported(accUnsup)
  );

  logic       dynSel;
  logic       rmBad;
  logic [2:0] effRm;

  always_comb begin
    dynSel   = (issRm == 3'b111);
    effRm    = dynSel ? rndQ : issRm;
    rmBad    = dynSel && (rndQ >= 3'b101);
    trapReq  = issValid && (rmBad || accUnsup);
    resValid = issValid && !trapReq;
    resRm    = resValid ? effRm : 3'd0;
    resAcc   = resValid ? grantAcc : 3'd0;
  end
endmodule

// File: rtl/fp_mode_csr.sv
module fp_mode_csr
  import fp_mode_pkg::*;
#(
  parameter int NUM_CLASS = 3,
  parameter int CLASS_W = 2,
  parameter logic [NUM_CLASS*8-1:0] ACC_SUPPORT = 24'h01_11_41,
  parameter bit PROMOTE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csrValid,
  input  logic [1:0]   csrOp,
  input  logic [1:0]   csrView,
  input  logic [31:0]  csrWdata,
  output logic [31:0]  csrRdata,
  input  logic         flagValid,
  input  logic [4:0]   flagBits,
  input  logic         issValid,
  input  logic [2:0]   issRm,
  input  logic [CLASS_W-1:0] issClass,
  output logic         resValid,
  output logic [2:0]   resRm,
  output logic [2:0]   resAcc,
  output logic         trapReq
);
  csr_strobe_t       strobe;
  logic [FLAG_W-1:0] flagsQ;
  logic [MODE_W-1:0] rndQ;
  logic [MODE_W-1:0] accQ;

  fp_mode_regs uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .flagValid(flagValid), .flagBits(flagBits),
    .flagsQ(flagsQ), .rndQ(rndQ), .accQ(accQ)
  );

  fp_mode_ctrl #(
    .NUM_CLASS(NUM_CLASS), .CLASS_W(CLASS_W),
    .ACC_SUPPORT(ACC_SUPPORT), .PROMOTE(PROMOTE)
  ) uCtrl (
    .csrValid(csrValid), .csrOp(csrOp), .csrView(csrView),
    .csrWdata(csrWdata), .csrRdata(csrRdata),
    .flagsQ(flagsQ), .rndQ(rndQ), .accQ(accQ), .strobe(strobe),
    .issValid(issValid), .issRm(issRm), .issClass(issClass),
    .resValid(resValid), .resRm(resRm), .resAcc(resAcc), .trapReq(trapReq)
  );
endmodule

// File: rtl/fp_mode_csr_chk.sv
module fp_mode_csr_chk #(
  parameter int CLASS_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               csrValid,
  input logic [1:0]         csrOp,
  input logic [1:0]         csrView,
  input logic               issValid,
  input logic [2:0]         issRm,
  input logic [CLASS_W-1:0] issClass,
  input logic               resValid,
  input logic [2:0]         resRm,
  input logic [2:0]         resAcc,
  input logic               trapReq,
  input logic [4:0]         flagsQ,
  input logic [2:0]         rndQ,
  input logic [2:0]         accQ
);
  logic flagTouch, rndTouch;
  assign flagTouch = csrValid && csrOp != 2'd0 && (csrView == 2'd0 || csrView == 2'd2);
  assign rndTouch  = csrValid && csrOp != 2'd0 && (csrView == 2'd0 || csrView == 2'd1);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (flagsQ == 5'd0 && rndQ == 3'd0 && accQ == 3'd0));

  // R5
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagTouch |=> (($past(flagsQ) & ~flagsQ) == 5'd0));

  // R3
  rnd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rndTouch |=> $stable(rndQ));

  // R6
  static_rm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && issRm != 3'b111) |-> (resRm == issRm));

  // R7
  dyn_rm_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && issRm == 3'b111 && rndQ >= 3'b101) |-> trapReq);

  // R9
  acc_not_looser_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resAcc <= accQ && !resAcc[0]));

  // R10
  odd_acc_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && accQ[0]) |-> trapReq);

  // R11
  trap_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (!resValid && resRm == 3'd0 && resAcc == 3'd0 && issValid));

  // R9
  class_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && int'(issClass) >= 3) |-> trapReq);
endmodule

bind fp_mode_csr fp_mode_csr_chk #(.CLASS_W(CLASS_W)) uChk (.*);

// File: tb/fp_mode_csr_test.sv
module fp_mode_csr_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrValid = 1'b0;
  logic [1:0] csrOp = '0, csrView = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic flagValid = 1'b0;
  logic [4:0] flagBits = '0;
  logic issValid = 1'b0;
  logic [2:0] issRm = '0;
  logic [1:0] issClass = '0;
  logic resValid, trapReq;
  logic [2:0] resRm, resAcc;

  int checks = 0;
  int errors = 0;

  logic [4:0] mFlags;
  logic [2:0] mRnd, mAcc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_mode_csr uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] opf(logic [1:0] op, logic [4:0] cur, logic [4:0] v);
    case (op)
      2'd1: return v;
      2'd2: return cur | v;
      2'd3: return cur & ~v;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] expRead();
    if (!csrValid) return 32'd0;
    case (csrView)
      2'd0: return {21'd0, mAcc, mRnd, mFlags};
      2'd1: return {29'd0, mRnd};
      2'd2: return {27'd0, mFlags};
      default: return {29'd0, mAcc};
    endcase
  endfunction

  // expected accuracy grant; returns 1 when the pair must trap
  function automatic bit expAcc(logic [2:0] acc, logic [1:0] cls, output logic [2:0] g);
    g = 3'd0;
    if (acc[0] || cls == 2'd3) return 1'b1;
    case (cls)
      2'd0: g = (acc == 3'b110) ? 3'b110 : 3'b000;
      2'd1: g = (acc >= 3'b100) ? 3'b100 : 3'b000;
      default: g = 3'b000;
    endcase
    return 1'b0;
  endfunction

  task automatic checkOutputs();
    logic [2:0] g, eRm, eAcc;
    bit aTrap, rTrap, eTrap, eVal;
    chk(csrRdata == expRead(), "R4 read view", csrRdata, expRead());
    aTrap = expAcc(mAcc, issClass, g);
    rTrap = (issRm == 3'b111) && (mRnd >= 3'b101);
    eTrap = issValid && (aTrap || rTrap);
    eVal  = issValid && !eTrap;
    eRm   = eVal ? ((issRm == 3'b111) ? mRnd : issRm) : 3'd0;
    eAcc  = eVal ? g : 3'd0;
    chk(trapReq == eTrap, "R9 trap", 32'(trapReq), 32'(eTrap));
    chk(resValid == eVal, "R11 valid", 32'(resValid), 32'(eVal));
    chk(resRm == eRm, "R6 rounding", 32'(resRm), 32'(eRm));
    chk(resAcc == eAcc, "R8 accuracy", 32'(resAcc), 32'(eAcc));
  endtask

  task automatic updateModel();
    logic [4:0] acc;
    bit ch;
    ch  = csrValid && csrOp != 2'd0;
    acc = mFlags | (flagValid ? flagBits : 5'd0);
    if (ch && (csrView == 2'd0 || csrView == 2'd2)) acc = opf(csrOp, acc, csrWdata[4:0]);
    if (ch && csrView == 2'd0) begin
      mRnd = 3'(opf(csrOp, {2'b0, mRnd}, {2'b0, csrWdata[7:5]}));
      mAcc = 3'(opf(csrOp, {2'b0, mAcc}, {2'b0, csrWdata[10:8]}));
    end
    if (ch && csrView == 2'd1) mRnd = 3'(opf(csrOp, {2'b0, mRnd}, {2'b0, csrWdata[2:0]}));
    if (ch && csrView == 2'd3) mAcc = 3'(opf(csrOp, {2'b0, mAcc}, {2'b0, csrWdata[2:0]}));
    mFlags = acc;
  endtask

  task automatic cyc(input logic cv, input logic [1:0] op, input logic [1:0] vw,
                     input logic [31:0] wd, input logic fv, input logic [4:0] fb,
                     input logic iv, input logic [2:0] rm, input logic [1:0] cl);
    @(negedge clk);
    csrValid = cv; csrOp = op; csrView = vw; csrWdata = wd;
    flagValid = fv; flagBits = fb; issValid = iv; issRm = rm; issClass = cl;
    #1;
    checkOutputs();
    @(posedge clk);
    updateModel();
  endtask

  task automatic idle();
    cyc(1'b0, 2'd0, 2'd0, 32'd0, 1'b0, 5'd0, 1'b0, 3'd0, 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    mFlags = '0; mRnd = '0; mAcc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state through the full view
    @(negedge clk);
    csrValid = 1'b1; csrView = 2'd0; csrOp = 2'd0;
    #1;
    chk(csrRdata == 32'd0, "R1 reset state", csrRdata, 32'd0);
    idle();

    // R2, R3: all-ones write, reserved bits read zero
    cyc(1'b1, 2'd1, 2'd0, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 3'd0, 2'd0);
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'd0; csrView = 2'd0;
    #1;
    chk(csrRdata == 32'h0000_07FF, "R2 packed layout", csrRdata, 32'h7FF);
    // R10: accuracy 111 traps
    issValid = 1'b1; issRm = 3'd0; issClass = 2'd0;
    #1;
    chk(trapReq == 1'b1, "R10 odd accuracy", 32'(trapReq), 32'd1);
    idle();

    // R4: field view aliases; clear accuracy, set frm to 101
    cyc(1'b1, 2'd1, 2'd3, 32'd0, 1'b0, 5'd0, 1'b0, 3'd0, 2'd0);
    cyc(1'b1, 2'd3, 2'd1, 32'h2, 1'b0, 5'd0, 1'b0, 3'd0, 2'd0);
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'd0; csrView = 2'd0;
    #1;
    chk(csrRdata == 32'h0000_00BF, "R4 alias via full", csrRdata, 32'hBF);
    // R7: dynamic with frm=101 traps; R6 static passes
    issValid = 1'b1; issRm = 3'b111; issClass = 2'd2;
    #1;
    chk(trapReq == 1'b1, "R7 reserved frm", 32'(trapReq), 32'd1);
    issRm = 3'b011;
    #1;
    chk(resValid && resRm == 3'b011, "R6 static pass", 32'(resRm), 32'h3);
    idle();

    // R5: clear wins over a colliding report, other reports accumulate
    cyc(1'b1, 2'd3, 2'd2, 32'h1F, 1'b1, 5'b10001, 1'b0, 3'd0, 2'd0);
    cyc(1'b0, 2'd0, 2'd0, 32'd0, 1'b1, 5'b00100, 1'b0, 3'd0, 2'd0);
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'd0; csrView = 2'd2;
    #1;
    chk(csrRdata == 32'h4, "R5 clear priority", csrRdata, 32'h4);
    idle();

    // R8, R9: accuracy grants
    cyc(1'b1, 2'd1, 2'd1, 32'h1, 1'b0, 5'd0, 1'b0, 3'd0, 2'd0);
    cyc(1'b1, 2'd1, 2'd3, 32'h6, 1'b0, 5'd0, 1'b0, 3'd0, 2'd0);
    @(negedge clk);
    issValid = 1'b1; issRm = 3'b111; issClass = 2'd0;
    #1;
    chk(resValid && resAcc == 3'b110 && resRm == 3'b001, "R8 exact grant", 32'(resAcc), 32'h6);
    issClass = 2'd1;
    #1;
    chk(resValid && resAcc == 3'b100, "R9 promote", 32'(resAcc), 32'h4);
    issClass = 2'd3;
    #1;
    chk(trapReq && !resValid, "R9 no support", 32'(trapReq), 32'd1);
    idle();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] rmv;
      rmv = ($urandom_range(1) == 0) ? 3'b111 : 3'($urandom);
      cyc(($urandom_range(9) < 3), 2'($urandom), 2'($urandom), $urandom,
          ($urandom_range(3) == 0), 5'($urandom),
          ($urandom_range(3) != 0), rmv, 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule